// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Arbiter

This block decides which of several bus masters may drive a single shared bus. The masters sit one after another in a chain behind a host processor. Each master has one request line and one local grant line. All requests are merged into a single shared hold request to the host. One clock later the host answers with an acknowledge. That acknowledge travels down the chain from the master nearest the host (index 0) towards the farthest one (index N-1). A master that is not requesting forwards the acknowledge unchanged. The first requesting master it meets absorbs it.

A master that sees the acknowledge while it is requesting, at a moment when nobody owns the bus, latches ownership. It keeps ownership until it drops its own request. Priority therefore comes only from position in the chain. An owner is never pre-empted, not even by a nearer master. When the owner releases, the acknowledge runs through again and the highest-priority waiter takes the bus.

Top module: `daisy_bus_arbiter`

## Requirements
- R1: `hold_o` is high in the same cycle as any bit of `req_i`, and low when all bits of `req_i` are low (combinational OR).
- R2: `holda_o` follows `hold_o` with a delay of exactly one clock: it rises at the first clock edge after `hold_o` rises, and it falls at the first clock edge after `hold_o` falls.
- R3: When the bus is free and several masters request together, only the lowest-index requester (index 0 is nearest the host) receives the grant. From an idle bus, a grant is visible after the second clock edge following the rise of its request.
- R4: A master that is not requesting passes the acknowledge on, so a far master (bit N-1) is granted when every nearer master is idle.
- R5: While an owner keeps its request high, its `grant_o` bit stays high and no other bit rises, even when a nearer master starts requesting (no pre-emption).
- R6: When the owner drops its request, its grant bit is low after the next clock edge. The highest-priority master still requesting is granted after the edge after that.
- R7: At most one bit of `grant_o` is high in any cycle, and a grant bit is only high if that master's request was high before the edge that produced it.
- R8: A synchronous active-low reset clears `grant_o` and `holda_o` after the clock edge at which `rst_n` is sampled low, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_MASTERS | Per-master bus request, bit 0 nearest the host |
| grant_o | output | N_MASTERS | Per-master local grant (ownership) |
| hold_o | output | 1 | Merged hold request to the host |
| holda_o | output | 1 | Host acknowledge entering the chain at master 0 |

## Verification
The bench builds the arbiter with four masters. With four, the test reaches both ends of the chain, and the two middle stages must pass the acknowledge through to reach the far end. It also makes a nearer stage start requesting behind a farther owner, which tests non-pre-emption. A table of request patterns walks through grant, release, hand-over and the rise and fall of the hold acknowledge. Directed steps then test reset taken in the middle of an ownership. A long stretch of random request patterns checks that no two grants are ever high together and that no grant appears without a request.

// File: rtl/daisy_arb_pkg.sv
// Package: types shared by the daisy-chain arbiter stages.
// Assumes nothing beyond IEEE 1800-2017 synthesizable types.
package daisy_arb_pkg;

    // State of one chain stage
    typedef enum logic [1:0] {
        CELL_IDLE = 2'b00,  // not requesting, acknowledge passes through
        CELL_WAIT = 2'b01,  // requesting, bus not yet owned
        CELL_OWN  = 2'b10   // requesting and owning the bus
    } cell_state_e;

endpackage

// File: rtl/daisy_host_ack.sv
// Module: daisy_host_ack
// Models the host side: registers the merged hold request and returns it
// as the acknowledge one clock later. Assumes the hold input is
// synchronous to clk. Reset is synchronous, active low.
module daisy_host_ack (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic ack_o
);

    logic ack_q;

    // Acknowledge register: follows hold with one cycle of delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= hold_i;
        end
    end

    assign ack_o = ack_q;

endmodule

// File: rtl/daisy_chain_cell.sv
// Module: daisy_chain_cell
// One stage of the grant chain. It forwards the incoming acknowledge
// while its master is idle and blocks it while the master requests. It
// latches ownership when the acknowledge arrives during a request and the
// bus is not busy, and keeps it until the request drops.
// Assumes bus_busy_i is high whenever any stage owns the bus.
module daisy_chain_cell
    import daisy_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ack_in_i,
    input  logic bus_busy_i,
    output logic ack_out_o,
    output logic own_o
);

    cell_state_e state_q;
    cell_state_e state_d;

    // Pass-or-absorb switch: a requesting stage opens the chain
    assign ack_out_o = ack_in_i & ~req_i;

    // Next-state decision for this stage
    always_comb begin
        state_d = state_q;
        case (state_q)
            CELL_OWN: begin
                state_d = req_i ? CELL_OWN : CELL_IDLE;
            end
            CELL_IDLE, CELL_WAIT: begin
                if (!req_i) begin
                    state_d = CELL_IDLE;
                end else if (ack_in_i && !bus_busy_i) begin
                    state_d = CELL_OWN;
                end else begin
                    state_d = CELL_WAIT;
                end
            end
            default: begin
                state_d = CELL_IDLE;
            end
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CELL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign own_o = (state_q == CELL_OWN);

endmodule

// File: rtl/daisy_bus_arbiter.sv
// Module: daisy_bus_arbiter
// Top of the daisy-chain arbiter. It merges all requests into one hold
// request, models the host acknowledge and ripples that acknowledge
// through N_MASTERS chain stages. Stage 0 is nearest the host.
// Assumes requests are synchronous to clk. Reset is synchronous, active low.
module daisy_bus_arbiter #(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    output logic [N_MASTERS-1:0] grant_o,
    output logic                 hold_o,
    output logic                 holda_o
);

    localparam int CHAIN_LEN = N_MASTERS + 1;

    logic [CHAIN_LEN-1:0] ack_chain;
    logic [N_MASTERS-1:0] own_vec;
    logic                 bus_busy;

    // Merged hold request: any master asking for the bus
    assign hold_o = |req_i;

    // Bus is busy while any stage owns it
    assign bus_busy = |own_vec;

    daisy_host_ack u_host (
        .clk   (clk),
        .rst_n (rst_n),
        .hold_i(hold_o),
        .ack_o (holda_o)
    );

    assign ack_chain[0] = holda_o;

    genvar gi;
    generate
        for (gi = 0; gi < N_MASTERS; gi++) begin : g_stage
            daisy_chain_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_i     (req_i[gi]),
                .ack_in_i  (ack_chain[gi]),
                .bus_busy_i(bus_busy),
                .ack_out_o (ack_chain[gi+1]),
                .own_o     (own_vec[gi])
            );
        end
    endgenerate

    assign grant_o = own_vec;

endmodule

// File: rtl/daisy_bus_arbiter_chk.sv
// Module: daisy_bus_arbiter_chk
// Property checker for daisy_bus_arbiter, attached through bind.
// Observes only the top-level ports.
module daisy_bus_arbiter_chk #(
    parameter int N_MASTERS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] req_i,
    input logic [N_MASTERS-1:0] grant_o,
    input logic                 hold_o,
    input logic                 holda_o
);

    localparam logic [N_MASTERS-1:0] ONE = {{(N_MASTERS-1){1'b0}}, 1'b1};

    logic [N_MASTERS-1:0] lowest_req;

    // Lowest-index requester, used to check position priority
    assign lowest_req = req_i & (~req_i + ONE);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R7

    AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> holda_o); // R2

    AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_o |=> !holda_o); // R2

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o & req_i) != '0) |=> (grant_o == $past(grant_o))); // R5

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o & ~req_i) != '0) |=> (grant_o == '0)); // R6

    AST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o != '0) && ($past(grant_o) == '0))
            |-> (grant_o == $past(lowest_req))); // R3

    AST_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o != '0) && ($past(grant_o) == '0)) |-> $past(holda_o)); // R4

endmodule

bind daisy_bus_arbiter daisy_bus_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .grant_o(grant_o),
    .hold_o (hold_o),
    .holda_o(holda_o)
);

// File: tb/tb_daisy_bus_arbiter.sv
`timescale 1ns/1ps
module tb_daisy_bus_arbiter;

    localparam int NM = 4;
    localparam int NVEC = 14;
    // Row: {req[3:0], expected grant[3:0], expected hold, expected holda}
    localparam logic [9:0] VEC [NVEC] = '{
        {4'b0001, 4'b0000, 1'b1, 1'b1},  // R2 ack rises, no grant yet
        {4'b0001, 4'b0001, 1'b1, 1'b1},  // R3 granted second edge
        {4'b0101, 4'b0001, 1'b1, 1'b1},  // R5 owner kept
        {4'b0100, 4'b0000, 1'b1, 1'b1},  // R6 release
        {4'b0100, 4'b0100, 1'b1, 1'b1},  // R6 hand-over
        {4'b0101, 4'b0100, 1'b1, 1'b1},  // R5 nearer master waits
        {4'b0001, 4'b0000, 1'b1, 1'b1},  // R6 release
        {4'b0001, 4'b0001, 1'b1, 1'b1},  // R6 hand-over
        {4'b0000, 4'b0000, 1'b0, 1'b0},  // R1 R2 all idle
        {4'b1010, 4'b0000, 1'b1, 1'b1},  // R2 ack back
        {4'b1010, 4'b0010, 1'b1, 1'b1},  // R3 lowest index wins
        {4'b1000, 4'b0000, 1'b1, 1'b1},  // R6 release
        {4'b1000, 4'b1000, 1'b1, 1'b1},  // R4 passes idle stages
        {4'b0000, 4'b0000, 1'b0, 1'b0}   // R1 R2 idle again
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req = '0;
    logic [NM-1:0] grant;
    logic          hold;
    logic          holda;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    daisy_bus_arbiter #(.N_MASTERS(NM)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req),
        .grant_o(grant),
        .hold_o (hold),
        .holda_o(holda)
    );

    task automatic check(input string tag, input logic [NM-1:0] act, input logic [NM-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // Drive at negedge, take one edge, sample shortly after it
    task automatic step(input logic [NM-1:0] r);
        @(negedge clk);
        req = r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [NM-1:0] prev;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset grant", grant, '0);
        check("R8 reset holda", {3'b0, holda}, 4'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][9:6]);
            check($sformatf("R3/R5/R6 row %0d grant", i), grant, VEC[i][5:2]);
            check($sformatf("R1 row %0d hold", i), {3'b0, hold}, {3'b0, VEC[i][1]});
            check($sformatf("R2 row %0d holda", i), {3'b0, holda}, {3'b0, VEC[i][0]});
        end

        // R8: reset taken while master 2 owns the bus
        step(4'b0100);
        step(4'b0100);
        check("R3 grant before reset", grant, 4'b0100);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R8 mid-run reset grant", grant, '0);
        check("R8 mid-run reset holda", {3'b0, holda}, 4'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b0100);
        check("R2 ack after reset", {3'b0, holda}, 4'b0001);
        step(4'b0100);
        check("R3 regrant after reset", grant, 4'b0100);

        // R7: random request patterns
        for (int k = 0; k < 400; k++) begin
            prev = NM'($urandom);
            if ((k % 5) != 0) prev = prev | grant;
            step(prev);
            total++;
            if ($countones(grant) > 1) begin
                fails++;
                $display("FAIL R7 one grant: actual %b expected at most one bit", grant);
            end
            check("R7 grant within requests", grant & ~prev, '0);
            check("R1 random hold", {3'b0, hold}, {3'b0, |prev});
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule